// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Engine

This block sits on the memory side of a shared-memory multicore and carries out exactly one request at a time against a small word-addressed storage array. It handles ordinary loads and stores as well as atomic operations: test-and-set, fetch-and-increment and fetch-and-decrement. Each operation runs through fixed phases: a read phase, an optional one-cycle modify phase, and a write phase. As a result, its latency is a constant that a worst-case timing analysis can rely on.

A request arrives on a valid/ready handshake carrying an operation code, a word address, write data and the id of the issuing core. When the last phase ends, the engine pulses a response carrying that core id. The response holds the old word for reads and atomics, or a store acknowledgement so that the core can move on. A scheduler that splits atomics can also issue a lone read phase of an atomic. The engine then reads and modifies the word but does not write it back. Instead, it offers the value to be written later on a separate update port, together with the core id and address.

Top module: `rmw_exec_engine`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and upd_valid are 0, and every storage word reads as 0.
- R2: Operation code 0 (load) keeps req_ready low for 5 cycles after the accepting edge. The response pulse appears in the following cycle, carrying the word stored at req_addr.
- R3: Operation code 1 (store) keeps the engine busy for 4 cycles and then writes req_wdata to req_addr. Its response has resp_ack set to 1 and resp_data set to 0.
- R4: Operation code 2 (test-and-set) is busy for 9 cycles: a 5-cycle read followed by a 4-cycle write of the value 1. It returns the old word.
- R5: Operation code 3 (fetch-and-increment) is busy for 10 cycles: read 5, modify 1, write 4. It returns the old word and stores the old word plus one, wrapping modulo 2^DATA_W.
- R6: Operation code 4 (fetch-and-decrement) is busy for 10 cycles. It returns the old word and stores the old word minus one, wrapping so that 0 becomes all ones.
- R7: While busy, req_ready stays 0. A request presented during that time is neither taken nor answered and leaves the storage unchanged.
- R8: resp_valid is high for exactly one cycle per accepted request, and resp_core equals the req_core that was accepted.
- R9: In the cycle carrying resp_valid, req_ready is already 1, so the next request can be accepted at the same edge.
- R10: Operation codes 5, 6 and 7 run only the read phase of test-and-set, increment and decrement. Codes 5, 6 and 7 are busy for 5, 6 and 6 cycles respectively. They return the old word and leave storage unchanged. In the response cycle, upd_valid pulses with upd_data set to 1, old+1 or old-1, and with upd_addr and upd_core taken from the request.
- R11: upd_valid stays 0 for operation codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken at this edge |
| req_op | input | 3 | Operation code (see R2 to R10) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_core | input | CORE_W | Issuing core id |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_core | output | CORE_W | Core id of the completed request |
| resp_data | output | DATA_W | Old word, or 0 for a store |
| resp_ack | output | 1 | Marks a store acknowledgement |
| upd_valid | output | 1 | Write-back value ready for a split atomic |
| upd_core | output | CORE_W | Core id for the write-back |
| upd_addr | output | ADDR_W | Address for the write-back |
| upd_data | output | DATA_W | Value to be written later |

## Verification
The two functions that can coincide are the completion of one request and the acceptance of the next. Both happen at the same edge, because the response cycle is also the first idle cycle. The stimulus walk provokes this on every vector by presenting the next request in the very cycle its predecessor's response is observed. Each response is then judged by its exact cycle count, its data and its core id. A stray request held during a busy period checks the opposite case: the engine must neither take it nor produce a second response.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
// Shared operation codes and phase encodings for the read-modify-write engine.
// Assumes the operation code is three bits wide and that all eight values are legal.
package rmw_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_TAS    = 3'd2,
        OP_FINC   = 3'd3,
        OP_FDEC   = 3'd4,
        OP_SP_TAS = 3'd5,
        OP_SP_INC = 3'd6,
        OP_SP_DEC = 3'd7
    } rmw_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_MOD   = 2'd2,
        PH_WRITE = 2'd3
    } rmw_phase_e;

    // Operation carries a read phase.
    function automatic logic op_reads(input rmw_op_e op);
        return op != OP_STORE;
    endfunction

    // Operation carries a one-cycle-class modify phase.
    function automatic logic op_modifies(input rmw_op_e op);
        return (op == OP_FINC) || (op == OP_FDEC) ||
               (op == OP_SP_INC) || (op == OP_SP_DEC);
    endfunction

    // Operation carries a write phase.
    function automatic logic op_writes(input rmw_op_e op);
        return (op == OP_STORE) || (op == OP_TAS) ||
               (op == OP_FINC) || (op == OP_FDEC);
    endfunction

    // Operation is the detached read phase of an atomic.
    function automatic logic op_split(input rmw_op_e op);
        return (op == OP_SP_TAS) || (op == OP_SP_INC) || (op == OP_SP_DEC);
    endfunction

    // Operation steps the value downward.
    function automatic logic op_down(input rmw_op_e op);
        return (op == OP_FDEC) || (op == OP_SP_DEC);
    endfunction

endpackage

// File: rtl/rmw_word_store.sv
`timescale 1ns/1ps
// Word-addressed storage array with one asynchronous read port and one
// synchronous write port. Assumes DEPTH is a power of two; every word clears on reset.
module rmw_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [DEPTH];

    // Clear all words on reset, otherwise commit the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Present the addressed word without a register stage.
    always_comb begin
        rd_data = words[rd_addr];
    end

endmodule

// File: rtl/rmw_modify.sv
`timescale 1ns/1ps
// Modify step of an atomic: adds or subtracts one, wrapping modulo 2^DATA_W.
// Purely combinational; the caller decides in which cycle the result is taken.
module rmw_modify #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic              step_down,
    output logic [DATA_W-1:0] new_val
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Select increment or decrement of the old value.
    always_comb begin
        if (step_down) begin
            new_val = old_val - ONE;
        end else begin
            new_val = old_val + ONE;
        end
    end

endmodule

// File: rtl/rmw_phase_seq.sv
`timescale 1ns/1ps
// Phase sequencer: walks an accepted operation through read, modify and write
// phases of fixed length with a per-phase down-counter. It reports the last cycle
// of each phase and of the whole operation. Assumes start only arrives while idle.
module rmw_phase_seq
    import rmw_pkg::*;
#(
    parameter int RD_CYC  = 5,
    parameter int MOD_CYC = 1,
    parameter int WR_CYC  = 4,
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ?
                             ((RD_CYC > MOD_CYC) ? RD_CYC : MOD_CYC) :
                             ((WR_CYC > MOD_CYC) ? WR_CYC : MOD_CYC),
    localparam int CNT_W = $clog2(MAX_CYC + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  rmw_op_e start_op,
    output logic    idle,
    output logic    rd_end,
    output logic    mod_end,
    output logic    wr_end,
    output logic    op_end
);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] MOD_LOAD = CNT_W'(MOD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);

    rmw_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    rmw_op_e          op_q;
    logic             last_cnt;

    // Decode the final cycle of the current phase.
    always_comb begin
        last_cnt = (cnt == '0);
        rd_end   = (phase == PH_READ)  && last_cnt;
        mod_end  = (phase == PH_MOD)   && last_cnt;
        wr_end   = (phase == PH_WRITE) && last_cnt;
        idle     = (phase == PH_IDLE);
    end

    // Flag the final cycle of the whole operation.
    always_comb begin
        op_end = wr_end ||
                 (mod_end && !op_writes(op_q)) ||
                 (rd_end && !op_modifies(op_q) && !op_writes(op_q));
    end

    // Advance phase and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            op_q  <= OP_LOAD;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        op_q <= start_op;
                        if (op_reads(start_op)) begin
                            phase <= PH_READ;
                            cnt   <= RD_LOAD;
                        end else begin
                            phase <= PH_WRITE;
                            cnt   <= WR_LOAD;
                        end
                    end
                end
                PH_READ: begin
                    if (!last_cnt) begin
                        cnt <= cnt - 1'b1;
                    end else if (op_modifies(op_q)) begin
                        phase <= PH_MOD;
                        cnt   <= MOD_LOAD;
                    end else if (op_writes(op_q)) begin
                        phase <= PH_WRITE;
                        cnt   <= WR_LOAD;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_MOD: begin
                    if (!last_cnt) begin
                        cnt <= cnt - 1'b1;
                    end else if (op_writes(op_q)) begin
                        phase <= PH_WRITE;
                        cnt   <= WR_LOAD;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: begin
                    if (!last_cnt) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rmw_exec_engine.sv
`timescale 1ns/1ps
// Top of the read-modify-write execution engine. Accepts one request when idle,
// runs it through fixed-length phases, answers with a one-cycle response pulse and,
// for detached atomic read phases, offers the value to write later on the update port.
// Assumes DEPTH is a power of two and that the requester honours req_ready.
module rmw_exec_engine
    import rmw_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int CORE_W  = 2,
    parameter int RD_CYC  = 5,
    parameter int MOD_CYC = 1,
    parameter int WR_CYC  = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CORE_W-1:0] req_core,
    output logic              resp_valid,
    output logic [CORE_W-1:0] resp_core,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_ack,
    output logic              upd_valid,
    output logic [CORE_W-1:0] upd_core,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data
);

    localparam logic [DATA_W-1:0] TAS_SET = DATA_W'(1);

    rmw_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CORE_W-1:0] core_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] mod_val;
    logic              accept;
    logic              idle;
    logic              rd_end;
    logic              mod_end;
    logic              wr_end;
    logic              op_end;

    // Handshake: take a request only while the sequencer is idle.
    always_comb begin
        req_ready = idle;
        accept    = req_valid && idle;
    end

    rmw_phase_seq #(
        .RD_CYC  (RD_CYC),
        .MOD_CYC (MOD_CYC),
        .WR_CYC  (WR_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_op (rmw_op_e'(req_op)),
        .idle     (idle),
        .rd_end   (rd_end),
        .mod_end  (mod_end),
        .wr_end   (wr_end),
        .op_end   (op_end)
    );

    rmw_word_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr_q),
        .rd_data (mem_rdata),
        .wr_en   (wr_end),
        .wr_addr (addr_q),
        .wr_data (new_q)
    );

    rmw_modify #(
        .DATA_W (DATA_W)
    ) u_mod (
        .old_val   (old_q),
        .step_down (op_down(op_q)),
        .new_val   (mod_val)
    );

    // Capture request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LOAD;
            addr_q <= '0;
            core_q <= '0;
        end else if (accept) begin
            op_q   <= rmw_op_e'(req_op);
            addr_q <= req_addr;
            core_q <= req_core;
        end
    end

    // Hold the old word at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else if (rd_end) begin
            old_q <= mem_rdata;
        end
    end

    // Build the value for the write phase: store data, set constant, or modified word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0;
        end else if (accept) begin
            new_q <= req_wdata;
        end else if (rd_end && (op_q == OP_TAS)) begin
            new_q <= TAS_SET;
        end else if (mod_end) begin
            new_q <= mod_val;
        end
    end

    // Drive the one-cycle response pulse at the end of the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_core  <= '0;
            resp_data  <= '0;
            resp_ack   <= 1'b0;
        end else begin
            resp_valid <= op_end;
            if (op_end) begin
                resp_core <= core_q;
                resp_ack  <= (op_q == OP_STORE);
                if (op_q == OP_STORE) begin
                    resp_data <= '0;
                end else if (rd_end) begin
                    resp_data <= mem_rdata;
                end else begin
                    resp_data <= old_q;
                end
            end
        end
    end

    // Offer the deferred write-back value for detached atomic read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_core  <= '0;
            upd_addr  <= '0;
            upd_data  <= '0;
        end else begin
            upd_valid <= op_end && op_split(op_q);
            if (op_end && op_split(op_q)) begin
                upd_core <= core_q;
                upd_addr <= addr_q;
                upd_data <= mod_end ? mod_val : TAS_SET;
            end
        end
    end

endmodule

// File: rtl/rmw_exec_chk.sv
`timescale 1ns/1ps
// Checker for the execution engine: tracks the accepted request with its own
// cycle counter and checks handshake, latency and response properties at the ports.
module rmw_exec_chk #(
    parameter int CORE_W  = 2,
    parameter int DATA_W  = 32,
    parameter int RD_CYC  = 5,
    parameter int MOD_CYC = 1,
    parameter int WR_CYC  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [CORE_W-1:0] req_core,
    input logic              resp_valid,
    input logic [CORE_W-1:0] resp_core,
    input logic [DATA_W-1:0] resp_data,
    input logic              resp_ack,
    input logic              upd_valid,
    input logic [CORE_W-1:0] upd_core
);

    localparam int AGE_W = 8;

    logic              in_flight;
    logic [AGE_W-1:0]  age;
    logic [2:0]        op_t;
    logic [CORE_W-1:0] core_t;
    logic [AGE_W-1:0]  want_age;

    // Expected response cycle (busy cycles plus one) for the tracked operation.
    always_comb begin
        case (op_t)
            3'd0:    want_age = AGE_W'(RD_CYC + 1);
            3'd1:    want_age = AGE_W'(WR_CYC + 1);
            3'd2:    want_age = AGE_W'(RD_CYC + WR_CYC + 1);
            3'd5:    want_age = AGE_W'(RD_CYC + 1);
            3'd6,
            3'd7:    want_age = AGE_W'(RD_CYC + MOD_CYC + 1);
            default: want_age = AGE_W'(RD_CYC + MOD_CYC + WR_CYC + 1);
        endcase
    end

    // Track the request in flight and count cycles since its acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= 1'b0;
            age       <= '0;
            op_t      <= '0;
            core_t    <= '0;
        end else if (req_valid && req_ready) begin
            in_flight <= 1'b1;
            age       <= AGE_W'(1);
            op_t      <= req_op;
            core_t    <= req_core;
        end else if (resp_valid) begin
            in_flight <= 1'b0;
        end else if (in_flight && (age != '1)) begin
            age <= age + 1'b1;
        end
    end

    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (in_flight && (age == want_age)));                  // R2
    AST_RESP_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_core == core_t));                             // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);                                       // R8
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                          // R7
    AST_READY_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);                                         // R9
    AST_STORE_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ack) |-> (resp_data == '0 && op_t == 3'd1));   // R3
    AST_UPD_SPLIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (resp_valid && op_t >= 3'd5));                       // R11
    AST_UPD_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_core == resp_core));                            // R10

endmodule

bind rmw_exec_engine rmw_exec_chk #(
    .CORE_W  (CORE_W),
    .DATA_W  (DATA_W),
    .RD_CYC  (RD_CYC),
    .MOD_CYC (MOD_CYC),
    .WR_CYC  (WR_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_core   (req_core),
    .resp_valid (resp_valid),
    .resp_core  (resp_core),
    .resp_data  (resp_data),
    .resp_ack   (resp_ack),
    .upd_valid  (upd_valid),
    .upd_core   (upd_core)
);

// File: tb/sim_rmw_exec_engine.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked back-to-back, then directed tests.
module sim_rmw_exec_engine;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int CORE_W = 2;
    localparam int ADDR_W = 4;

    typedef struct packed {
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CORE_W-1:0] core;
        logic [DATA_W-1:0] exp;
        logic [4:0]        busy;
        logic              ack;
        logic              upd;
        logic [DATA_W-1:0] upd_exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'd3, 32'h10,       2'd1, 32'h0,        5'd4,  1'b1, 1'b0, 32'h0},        // R3 store
        '{3'd0, 4'd3, 32'h0,        2'd2, 32'h10,       5'd5,  1'b0, 1'b0, 32'h0},        // R2 load
        '{3'd3, 4'd3, 32'h0,        2'd0, 32'h10,       5'd10, 1'b0, 1'b0, 32'h0},        // R5 inc
        '{3'd0, 4'd3, 32'h0,        2'd1, 32'h11,       5'd5,  1'b0, 1'b0, 32'h0},        // R5 result
        '{3'd4, 4'd3, 32'h0,        2'd3, 32'h11,       5'd10, 1'b0, 1'b0, 32'h0},        // R6 dec
        '{3'd0, 4'd3, 32'h0,        2'd2, 32'h10,       5'd5,  1'b0, 1'b0, 32'h0},        // R6 result
        '{3'd2, 4'd5, 32'h0,        2'd1, 32'h0,        5'd9,  1'b0, 1'b0, 32'h0},        // R4 tas free
        '{3'd2, 4'd5, 32'h0,        2'd2, 32'h1,        5'd9,  1'b0, 1'b0, 32'h0},        // R4 tas held
        '{3'd0, 4'd5, 32'h0,        2'd0, 32'h1,        5'd5,  1'b0, 1'b0, 32'h0},        // R4 result
        '{3'd1, 4'd7, 32'hFFFFFFFF, 2'd3, 32'h0,        5'd4,  1'b1, 1'b0, 32'h0},        // R3 store max
        '{3'd3, 4'd7, 32'h0,        2'd1, 32'hFFFFFFFF, 5'd10, 1'b0, 1'b0, 32'h0},        // R5 wrap
        '{3'd0, 4'd7, 32'h0,        2'd1, 32'h0,        5'd5,  1'b0, 1'b0, 32'h0},        // R5 wrapped
        '{3'd4, 4'd7, 32'h0,        2'd2, 32'h0,        5'd10, 1'b0, 1'b0, 32'h0},        // R6 wrap
        '{3'd0, 4'd7, 32'h0,        2'd3, 32'hFFFFFFFF, 5'd5,  1'b0, 1'b0, 32'h0},        // R6 wrapped
        '{3'd6, 4'd3, 32'h0,        2'd2, 32'h10,       5'd6,  1'b0, 1'b1, 32'h11},       // R10 split inc
        '{3'd0, 4'd3, 32'h0,        2'd0, 32'h10,       5'd5,  1'b0, 1'b0, 32'h0},        // R10 unchanged
        '{3'd7, 4'd7, 32'h0,        2'd1, 32'hFFFFFFFF, 5'd6,  1'b0, 1'b1, 32'hFFFFFFFE}, // R10 split dec
        '{3'd5, 4'd5, 32'h0,        2'd3, 32'h1,        5'd5,  1'b0, 1'b1, 32'h1},        // R10 split tas
        '{3'd1, 4'd0, 32'hA5A5,     2'd3, 32'h0,        5'd4,  1'b1, 1'b0, 32'h0},        // R3 store
        '{3'd0, 4'd0, 32'h0,        2'd0, 32'hA5A5,     5'd5,  1'b0, 1'b0, 32'h0}         // R2 load
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [CORE_W-1:0] req_core = '0;
    logic              resp_valid;
    logic [CORE_W-1:0] resp_core;
    logic [DATA_W-1:0] resp_data;
    logic              resp_ack;
    logic              upd_valid;
    logic [CORE_W-1:0] upd_core;
    logic [ADDR_W-1:0] upd_addr;
    logic [DATA_W-1:0] upd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rmw_exec_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
        .resp_valid(resp_valid), .resp_core(resp_core), .resp_data(resp_data),
        .resp_ack(resp_ack), .upd_valid(upd_valid), .upd_core(upd_core),
        .upd_addr(upd_addr), .upd_data(upd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            default: return "R10";
        endcase
    endfunction

    // Issue one request at the current negedge and follow it to its response.
    task automatic run(input vec_t v);
        int n;
        string t;
        t = tag_of(v.op);
        req_valid = 1'b1;
        req_op    = v.op;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        req_core  = v.core;
        chk(req_ready == 1'b1, "R9 ready when issuing", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!resp_valid && n < 40) begin
            if (req_ready || upd_valid) begin
                chk(1'b0, "R7 busy window", {30'd0, req_ready, upd_valid}, 32'd0);
            end
            @(negedge clk);
            n++;
        end
        chk(n == int'(v.busy) + 1, {t, " response cycle"}, 32'(n), 32'(v.busy + 1));
        chk(resp_data == v.exp, {t, " response data"}, resp_data, v.exp);
        chk(resp_core == v.core, "R8 response core", 32'(resp_core), 32'(v.core));
        chk(resp_ack == v.ack, {t, " ack flag"}, 32'(resp_ack), 32'(v.ack));
        chk(req_ready == 1'b1, "R9 ready with response", 32'(req_ready), 32'd1);
        if (v.upd) begin
            chk(upd_valid == 1'b1, "R10 update pulse", 32'(upd_valid), 32'd1);
            chk(upd_data == v.upd_exp, "R10 update data", upd_data, v.upd_exp);
            chk(upd_addr == v.addr, "R10 update addr", 32'(upd_addr), 32'(v.addr));
            chk(upd_core == v.core, "R10 update core", 32'(upd_core), 32'(v.core));
        end else begin
            chk(upd_valid == 1'b0, "R11 no update", 32'(upd_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t hold;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1 resp idle", 32'(resp_valid), 32'd0);
        chk(upd_valid == 1'b0, "R1 upd idle", 32'(upd_valid), 32'd0);
        // R1: storage clear
        run('{3'd0, 4'd9, 32'h0, 2'd1, 32'h0, 5'd5, 1'b0, 1'b0, 32'h0});

        // Vector walk, each request issued in its predecessor's response cycle (R9).
        for (int i = 0; i < NV; i++) begin
            run(VECS[i]);
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8 single-cycle pulse", 32'(resp_valid), 32'd0);

        // R7: a store offered while busy must be ignored.
        req_valid = 1'b1; req_op = 3'd0; req_addr = 4'd0; req_core = 2'd2;
        @(posedge clk);
        @(negedge clk);
        req_op = 3'd1; req_wdata = 32'h1234; req_core = 2'd1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R7 not ready while busy", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        chk(resp_data == 32'hA5A5, "R7 load during stray request", resp_data, 32'hA5A5);
        chk(resp_core == 2'd2, "R8 core kept", 32'(resp_core), 32'd2);
        repeat (8) begin
            @(negedge clk);
            chk(resp_valid == 1'b0, "R7 stray not answered", 32'(resp_valid), 32'd0);
        end
        hold = '{3'd0, 4'd0, 32'h0, 2'd3, 32'hA5A5, 5'd5, 1'b0, 1'b0, 32'h0};
        run(hold); // R7 storage untouched

        // R1: reset mid-operation returns to idle and clears storage.
        req_valid = 1'b1; req_op = 3'd3; req_addr = 4'd3; req_core = 2'd0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        run('{3'd0, 4'd3, 32'h0, 2'd1, 32'h0, 5'd5, 1'b0, 1'b0, 32'h0});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule